// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 level-sensitive interrupt inputs and turns them into two request lines for a processor core. One line is for urgent ("fast") interrupts and one is for ordinary ("normal") interrupts. Each source has four settings: an enable bit, a routing bit that makes it fast or normal, a 4-bit priority, and a force bit. The force bit lets software make the source pending without any activity on the input.

The source number of the winning normal interrupt and its priority are published together in one 32-bit status word. A handler reads that word once and jumps through a table indexed by the number. Two per-source pending words, one for normal and one for fast sources, show which sources are currently both enabled and active. Pending state follows the inputs: a source stops being pending once its input and its force bit are both low. All outputs are registered, so they follow a change at the inputs by exactly one clock. Nesting, mode changes and context saving are left to software.

Configuration arrives on plain parallel pins, which a register bank elsewhere drives. No data streams through the block, so it has no handshake.

Top module: `prio_vec_intc`

## Requirements
- R1: A source whose enable bit is 0 is never pending: its pending bit stays 0 and it takes no part in arbitration or in either request line.
- R2: A set force bit makes an enabled source pending while its input is low.
- R3: A source with routing bit 1 is fast. It appears only in `fast_pend_o` and drives `fast_req_o`. It never appears in `norm_pend_o` or in the vector status.
- R4: Bit i of `norm_pend_o` is 1 exactly when source i is enabled, normal, and has its input or force bit high. Bit 0 belongs to source 0.
- R5: `vec_status_o` holds the winning normal source number in bits 31:16 and its priority in bits 3:0. Bits 15:4 are always 0.
- R6: Priority 15 is the highest and 0 the lowest. The pending normal source with the highest priority wins.
- R7: Among pending normal sources that share the highest priority, the lowest source number wins.
- R8: With no normal source pending, bits 31:16 read 0xFFFF, bits 3:0 read 0, and `norm_req_o` is 0.
- R9: Pending is level based. A source that drops its input, with its force bit low, is no longer pending on the next cycle.
- R10: During reset, both pending words and both request lines are 0, and `vec_status_o` is 0xFFFF0000.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 64 | Interrupt input levels, bit i = source i |
| en_i | input | 64 | Per-source enable |
| fast_sel_i | input | 64 | Routing bit, 1 = fast, 0 = normal |
| force_i | input | 64 | Per-source software force |
| prio_i | input | 256 | Priorities, source i at bits 4i+3:4i |
| fast_req_o | output | 1 | Fast request to the core |
| norm_req_o | output | 1 | Normal request to the core |
| vec_status_o | output | 32 | Winning normal number (31:16) and priority (3:0) |
| norm_pend_o | output | 64 | Pending normal sources |
| fast_pend_o | output | 64 | Pending fast sources |

## Verification
A fault in the pending logic shows up one cycle later in three places: a wrong pending bit, a request line with the wrong level, or a vector that names a source that is not pending. A fault in the arbitration tree has a narrower signature. The vector names a pending source, but another pending normal source has a higher priority, or has the same priority and a lower number. Because the block keeps no state beyond one register stage, every fault appears at the ports within one clock of the stimulus that exposes it. The bench therefore compares every output with an independent model on every applied pattern.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W = 16;

  typedef struct packed {
    logic             valid;
    logic [3:0]       prio;
    logic [VEC_W-1:0] idx;
  } cand_t;

  // Left operand always carries the lower source numbers.
  function automatic cand_t pick(input cand_t lo, input cand_t hi);
    if (lo.valid && (!hi.valid || lo.prio >= hi.prio)) return lo;
    return hi;
  endfunction
endpackage

// File: rtl/intc_pend_gen.sv
module intc_pend_gen #(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] fast_sel_i,
  input  logic [NUM_SRC-1:0] force_i,
  output logic [NUM_SRC-1:0] norm_pend_o,
  output logic [NUM_SRC-1:0] fast_pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    assign live           = (src_i[i] | force_i[i]) & en_i[i];
    assign norm_pend_o[i] = live & ~fast_sel_i[i];
    assign fast_pend_o[i] = live &  fast_sel_i[i];
  end
endmodule

// File: rtl/intc_arb_tree.sv
module intc_arb_tree
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output cand_t                     win_o
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_SRC) begin : g_real
      assign node[LEAVES-1+l] = '{valid: req_i[l],
                                  prio:  4'(prio_i[l*PRIO_W +: PRIO_W]),
                                  idx:   VEC_W'(l)};
    end else begin : g_pad
      assign node[LEAVES-1+l] = '{valid: 1'b0, prio: 4'd0, idx: VEC_W'(l)};
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    assign node[n] = pick(node[2*n+1], node[2*n+2]);
  end

  assign win_o = node[0];
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC-1:0]        fast_sel_i,
  input  logic [NUM_SRC-1:0]        force_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      fast_req_o,
  output logic                      norm_req_o,
  output logic [31:0]               vec_status_o,
  output logic [NUM_SRC-1:0]        norm_pend_o,
  output logic [NUM_SRC-1:0]        fast_pend_o
);
  localparam logic [31:0] IDLE_VEC = {16'hFFFF, 16'h0000};

  logic [NUM_SRC-1:0] norm_pend_d, fast_pend_d;
  cand_t              win;
  logic [31:0]        vec_d;

  intc_pend_gen #(.NUM_SRC(NUM_SRC)) u_pend (
    .src_i       (src_i),
    .en_i        (en_i),
    .fast_sel_i  (fast_sel_i),
    .force_i     (force_i),
    .norm_pend_o (norm_pend_d),
    .fast_pend_o (fast_pend_d)
  );

  intc_arb_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i  (norm_pend_d),
    .prio_i (prio_i),
    .win_o  (win)
  );

  always_comb begin
    vec_d = IDLE_VEC;
    if (win.valid) vec_d = {win.idx, 12'h000, win.prio};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_pend_o  <= '0;
      fast_pend_o  <= '0;
      fast_req_o   <= 1'b0;
      norm_req_o   <= 1'b0;
      vec_status_o <= IDLE_VEC;
    end else begin
      norm_pend_o  <= norm_pend_d;
      fast_pend_o  <= fast_pend_d;
      fast_req_o   <= |fast_pend_d;
      norm_req_o   <= win.valid;
      vec_status_o <= vec_d;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        en_i,
  input logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input logic                      fast_req_o,
  input logic                      norm_req_o,
  input logic [31:0]               vec_status_o,
  input logic [NUM_SRC-1:0]        norm_pend_o,
  input logic [NUM_SRC-1:0]        fast_pend_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                      armed;
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [IW-1:0]             widx;
  logic                      beaten;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      armed  <= 1'b1;
      en_q   <= en_i;
      prio_q <= prio_i;
    end
  end

  assign widx = vec_status_o[16 +: IW];

  always_comb begin
    beaten = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (norm_pend_o[i] && norm_req_o) begin
        if (prio_q[i*PRIO_W +: PRIO_W] > prio_q[widx*PRIO_W +: PRIO_W]) beaten = 1'b1;
        if (prio_q[i*PRIO_W +: PRIO_W] == prio_q[widx*PRIO_W +: PRIO_W] && i < int'(widx))
          beaten = 1'b1;
      end
    end
  end

  // R1
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((norm_pend_o | fast_pend_o) & ~en_q) == '0);
  // R3
  route_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend_o & fast_pend_o) == '0 && fast_req_o == (|fast_pend_o));
  // R5
  vec_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && norm_req_o) |-> (norm_pend_o[widx] &&
      vec_status_o[3:0] == 4'(prio_q[widx*PRIO_W +: PRIO_W]) && vec_status_o[15:4] == 12'h0));
  // R6
  best_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !beaten);
  // R8
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend_o == '0) |-> (!norm_req_o && vec_status_o == 32'hFFFF0000));
endmodule

bind prio_vec_intc intc_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .prio_i       (prio_i),
  .fast_req_o   (fast_req_o),
  .norm_req_o   (norm_req_o),
  .vec_status_o (vec_status_o),
  .norm_pend_o  (norm_pend_o),
  .fast_pend_o  (fast_pend_o)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  localparam int N = 64;

  typedef struct packed {
    logic [63:0] src, en, fast, frc;
    logic [7:0]  pmul, padd;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{64'h0, 64'h0, 64'h0, 64'h0, 8'd1, 8'd0},
    '{{64{1'b1}}, {64{1'b1}}, 64'h0, 64'h0, 8'd1, 8'd0},
    '{64'h8000_0000_0000_0001, {64{1'b1}}, 64'h0, 64'h0, 8'd0, 8'd5},
    '{{64{1'b1}}, 64'h00FF_00FF_F0F0_1234, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 8'd3, 8'd2},
    '{64'h0, {64{1'b1}}, 64'h0, 64'h0000_0100_0000_0000, 8'd1, 8'd0},
    '{{64{1'b1}}, 64'h0, 64'h0, {64{1'b1}}, 8'd1, 8'd0},
    '{64'hDEAD_BEEF_0BAD_F00D, {64{1'b1}}, {64{1'b1}}, 64'h0, 8'd5, 8'd1},
    '{64'hA5A5_3C3C_9999_1111, 64'hFFFF_0000_FFFF_FF00, 64'h0000_0003_0000_0F00, 64'h0020_0000_0000_0001, 8'd7, 8'd3}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src_i = '0, en_i = '0, fast_sel_i = '0, force_i = '0;
  logic [N*4-1:0] prio_i = '0;
  logic           fast_req_o, norm_req_o;
  logic [31:0]    vec_status_o;
  logic [N-1:0]   norm_pend_o, fast_pend_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  prio_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .en_i(en_i), .fast_sel_i(fast_sel_i),
    .force_i(force_i), .prio_i(prio_i), .fast_req_o(fast_req_o), .norm_req_o(norm_req_o),
    .vec_status_o(vec_status_o), .norm_pend_o(norm_pend_o), .fast_pend_o(fast_pend_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic set_prio(input logic [7:0] mul, input logic [7:0] add);
    for (int i = 0; i < N; i++) prio_i[i*4 +: 4] = 4'((i * mul + add) % 16);
  endtask

  // Reference model built from R1..R8.
  task automatic verify(input string tag);
    logic [N-1:0] live, np, fp;
    logic [31:0]  ev;
    int           best;
    live = (src_i | force_i) & en_i;
    np   = live & ~fast_sel_i;
    fp   = live &  fast_sel_i;
    best = -1;
    for (int i = 0; i < N; i++)
      if (np[i] && (best < 0 || prio_i[i*4 +: 4] > prio_i[best*4 +: 4])) best = i;
    ev = (best < 0) ? 32'hFFFF0000 : {16'(best), 12'h0, prio_i[best*4 +: 4]};
    @(posedge clk);
    @(negedge clk);
    check({tag, " R4 norm_pend"}, norm_pend_o, np);
    check({tag, " R3 fast_pend"}, fast_pend_o, fp);
    check({tag, " R3 fast_req"}, 64'(fast_req_o), 64'(|fp));
    check({tag, " R8 norm_req"}, 64'(norm_req_o), 64'(best >= 0));
    check({tag, " R5_R6_R7 vec"}, 64'(vec_status_o), 64'(ev));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    src_i = '1; en_i = '1; force_i = '1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 norm_pend", norm_pend_o, '0);
    check("R10 fast_pend", fast_pend_o, '0);
    check("R10 reqs", {62'h0, fast_req_o, norm_req_o}, 64'h0);
    check("R10 vec", 64'(vec_status_o), 64'hFFFF0000);
    src_i = '0; en_i = '0; force_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      src_i = TBL[k].src; en_i = TBL[k].en; fast_sel_i = TBL[k].fast; force_i = TBL[k].frc;
      set_prio(TBL[k].pmul, TBL[k].padd);
      verify($sformatf("tbl%0d", k));
    end

    // R7 all priorities equal: lowest number wins
    src_i = '0; force_i = '0; fast_sel_i = '0; en_i = '1; set_prio(8'd0, 8'd0);
    src_i[9] = 1'b1; src_i[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 tie", 64'(vec_status_o), 64'h0005_0000);

    // R1 disabled prio-15 source loses to enabled prio-1 source
    prio_i[2*4 +: 4] = 4'd15; prio_i[30*4 +: 4] = 4'd1;
    src_i = '0; src_i[2] = 1'b1; src_i[30] = 1'b1; en_i[2] = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 masked", 64'(vec_status_o), 64'h001E_0001);
    check("R1 pend", norm_pend_o, 64'h0000_0000_4000_0000);

    // R2 force alone
    src_i = '0; force_i[2] = 1'b1; en_i[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 force", 64'(vec_status_o), 64'h0002_000F);

    // R9 level clear, R11 latency
    force_i = '0; src_i = '0; src_i[12] = 1'b1; prio_i[12*4 +: 4] = 4'd6;
    @(posedge clk); @(negedge clk);
    check("R11 set", 64'(vec_status_o), 64'h000C_0006);
    src_i[12] = 1'b0;
    #2;
    check("R11 hold before edge", 64'(norm_req_o), 64'h1);
    @(posedge clk); @(negedge clk);
    check("R9 cleared", norm_pend_o, '0);
    check("R9 idle vec", 64'(vec_status_o), 64'hFFFF0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule